// File: doc/BRIEF.md
# Countdown Watchdog with Gated Reset Request

This block is a 32-bit countdown watchdog reached over a simple single-cycle register bus. Software loads the count by writing it and reads it back at any time. A bit in a control register lets the count fall by one on every clock, and the count stops at zero rather than wrapping. A separate arm register decides whether a zero count turns into a reset request. If software arms the block while the count already sits at zero, the request goes high at once. Software keeps the system alive by rewriting the count before it runs out.

A four-state machine follows the values the registers will hold after each clock edge. The states are `ST_HALTED` (count frozen and nonzero), `ST_COUNTING` (count enabled and nonzero), `ST_EXPIRED` (count zero, not armed) and `ST_BITING` (count zero and armed). Every transition is named for the state it enters. Any state moves to `ST_BITING` when the next count is zero and the arm bit is set. It moves to `ST_EXPIRED` when the next count is zero and the arm bit is clear. Otherwise it moves to `ST_COUNTING` if counting is enabled and to `ST_HALTED` if it is not. The reset request is high only in `ST_BITING`.

Top module: `wdog_countdown`

## Requirements
- R1: While and after reset, the count reads 0x7FFFFFFF, the control register reads 0x07, the arm register reads 0x00 and `wd_rst_req` is low. With these values the count does not change.
- R2: The count is at address 0x20324, the control register at 0x20300 and the arm register at 0x20108. A read strobe at one clock edge puts the addressed value, zero-extended to 32 bits, on `bus_rdata` after that edge. An unmapped address reads as 0. Without a read strobe, `bus_rdata` is 0.
- R3: While control bit 4 is 1, the count falls by exactly one on each clock edge. The first fall happens on the edge after the edge that writes the bit.
- R4: The count stops at zero and never wraps to 0xFFFFFFFF.
- R5: While control bit 4 is 0, the count keeps its current value.
- R6: A count write on an edge where a decrement would also happen stores the written value.
- R7: `wd_rst_req` is a registered level. It is high after an edge exactly when the count is zero and arm bit 1 is set after that edge. This covers the case where the arm bit is set while the count is already zero.
- R8: While arm bit 1 is clear, a zero count raises no reset request. The other arm bits are stored and read back but have no effect.
- R9: Reloading the count with a nonzero value, or clearing arm bit 1, drops `wd_rst_req` on the same edge.
- R10: A write to an unmapped address changes no register. Reading the count returns its live value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 20 | Register address |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_rdata | output | 32 | Registered read data |
| wd_rst_req | output | 1 | Active-high reset request |

## Verification
The assertions assume that the bus inputs hold known values after reset. They also assume that a write strobe names one address per cycle, so the decrement, freeze and write-priority properties can read the bus ports directly. The bench changes every input only at the falling clock edge and drops each strobe after one edge. Reads, writes and idle cycles never overlap, so each property sees a single bus operation per cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int unsigned WD_DATA_W = 32;
    localparam int unsigned WD_ADDR_W = 20;

    localparam logic [WD_ADDR_W-1:0] WD_ADDR_COUNT = 20'h20324;
    localparam logic [WD_ADDR_W-1:0] WD_ADDR_CTRL  = 20'h20300;
    localparam logic [WD_ADDR_W-1:0] WD_ADDR_ARM   = 20'h20108;

    typedef enum logic [1:0] {
        ST_HALTED   = 2'd0,
        ST_COUNTING = 2'd1,
        ST_EXPIRED  = 2'd2,
        ST_BITING   = 2'd3
    } wd_state_e;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs #(
    parameter int unsigned ADDR_W    = 20,
    parameter int unsigned CTRL_W    = 8,
    parameter int unsigned ARM_W     = 8,
    parameter int unsigned EN_BIT    = 4,
    parameter int unsigned ARM_BIT   = 1,
    parameter logic [CTRL_W-1:0] CTRL_RST = 8'h07,
    parameter logic [ADDR_W-1:0] A_COUNT = 20'h20324,
    parameter logic [ADDR_W-1:0] A_CTRL  = 20'h20300,
    parameter logic [ADDR_W-1:0] A_ARM   = 20'h20108
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata_ctrl,
    input  logic [ARM_W-1:0]  wdata_arm,
    output logic              count_wr,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [ARM_W-1:0]  arm_q,
    output logic              en_q,
    output logic              en_d,
    output logic              arm_d
);

    logic              ctrl_wr;
    logic              arm_wr;
    logic [CTRL_W-1:0] ctrl_d;
    logic [ARM_W-1:0]  arm_reg_d;

    assign count_wr = we && (addr == A_COUNT);
    assign ctrl_wr  = we && (addr == A_CTRL);
    assign arm_wr   = we && (addr == A_ARM);

    always_comb begin
        ctrl_d    = ctrl_wr ? wdata_ctrl : ctrl_q;
        arm_reg_d = arm_wr  ? wdata_arm  : arm_q;
    end

    assign en_q  = ctrl_q[EN_BIT];
    assign en_d  = ctrl_d[EN_BIT];
    assign arm_d = arm_reg_d[ARM_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
            arm_q  <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            arm_q  <= arm_reg_d;
        end
    end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int unsigned CNT_W = 32,
    parameter logic [CNT_W-1:0] CNT_RST = 32'h7FFF_FFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_q,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_d
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic at_zero;

    assign at_zero = (cnt_q == '0);

    always_comb begin
        if (load) begin
            cnt_d = load_val;
        end else if (en_q && !at_zero) begin
            cnt_d = cnt_q - ONE;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CNT_RST;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_d,
    input  logic             en_d,
    input  logic             arm_d,
    output wd_state_e        state_q,
    output logic             rst_req
);

    wd_state_e state_d;
    logic      zero_next;

    assign zero_next = (cnt_d == '0);

    always_comb begin
        unique case (state_q)
            ST_HALTED, ST_COUNTING, ST_EXPIRED, ST_BITING: begin
                if (zero_next) begin
                    state_d = arm_d ? ST_BITING : ST_EXPIRED;
                end else begin
                    state_d = en_d ? ST_COUNTING : ST_HALTED;
                end
            end
            default: state_d = ST_HALTED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALTED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_BITING:   rst_req = 1'b1;
            ST_HALTED,
            ST_COUNTING,
            ST_EXPIRED:  rst_req = 1'b0;
            default:     rst_req = 1'b0;
        endcase
    end

endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown
    import wdog_pkg::*;
#(
    parameter int unsigned DATA_W  = WD_DATA_W,
    parameter int unsigned ADDR_W  = WD_ADDR_W,
    parameter int unsigned CTRL_W  = 8,
    parameter int unsigned ARM_W   = 8,
    parameter int unsigned EN_BIT  = 4,
    parameter int unsigned ARM_BIT = 1,
    parameter logic [ADDR_W-1:0] A_COUNT = WD_ADDR_COUNT,
    parameter logic [ADDR_W-1:0] A_CTRL  = WD_ADDR_CTRL,
    parameter logic [ADDR_W-1:0] A_ARM   = WD_ADDR_ARM
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wd_rst_req
);

    localparam logic [DATA_W-1:0] CNT_RST  = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [CTRL_W-1:0] CTRL_RST = CTRL_W'(7);

    logic              count_wr;
    logic [CTRL_W-1:0] ctrl_q;
    logic [ARM_W-1:0]  arm_q;
    logic              en_q;
    logic              en_d;
    logic              arm_d;
    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] cnt_d;
    logic [DATA_W-1:0] rd_mux;
    wd_state_e         state_q;

    wdog_regs #(
        .ADDR_W  (ADDR_W),
        .CTRL_W  (CTRL_W),
        .ARM_W   (ARM_W),
        .EN_BIT  (EN_BIT),
        .ARM_BIT (ARM_BIT),
        .CTRL_RST(CTRL_RST),
        .A_COUNT (A_COUNT),
        .A_CTRL  (A_CTRL),
        .A_ARM   (A_ARM)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (bus_addr),
        .we        (bus_we),
        .wdata_ctrl(bus_wdata[CTRL_W-1:0]),
        .wdata_arm (bus_wdata[ARM_W-1:0]),
        .count_wr  (count_wr),
        .ctrl_q    (ctrl_q),
        .arm_q     (arm_q),
        .en_q      (en_q),
        .en_d      (en_d),
        .arm_d     (arm_d)
    );

    wdog_counter #(
        .CNT_W  (DATA_W),
        .CNT_RST(CNT_RST)
    ) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_q    (en_q),
        .load    (count_wr),
        .load_val(bus_wdata),
        .cnt_q   (cnt_q),
        .cnt_d   (cnt_d)
    );

    wdog_fsm #(
        .CNT_W(DATA_W)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_d  (cnt_d),
        .en_d   (en_d),
        .arm_d  (arm_d),
        .state_q(state_q),
        .rst_req(wd_rst_req)
    );

    always_comb begin
        rd_mux = '0;
        if (bus_addr == A_COUNT) begin
            rd_mux = cnt_q;
        end else if (bus_addr == A_CTRL) begin
            rd_mux = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
        end else if (bus_addr == A_ARM) begin
            rd_mux = {{(DATA_W-ARM_W){1'b0}}, arm_q};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else begin
            bus_rdata <= bus_rd ? rd_mux : '0;
        end
    end

endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned ARM_W  = 8,
    parameter int unsigned ARM_BIT = 1,
    parameter logic [ADDR_W-1:0] A_COUNT = 20'h20324,
    parameter logic [ADDR_W-1:0] A_CTRL  = 20'h20300,
    parameter logic [ADDR_W-1:0] A_ARM   = 20'h20108
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              wd_rst_req,
    input logic [DATA_W-1:0] cnt_q,
    input logic              en_q,
    input logic [ARM_W-1:0]  arm_q
);

    logic cnt_hit;
    logic unmapped;

    assign cnt_hit  = bus_we && (bus_addr == A_COUNT);
    assign unmapped = (bus_addr != A_COUNT) && (bus_addr != A_CTRL) &&
                      (bus_addr != A_ARM);

    // R7
    rst_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst_req == ((cnt_q == '0) && arm_q[ARM_BIT]));

    // R3
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && (cnt_q != '0) && !cnt_hit) |=> (cnt_q == $past(cnt_q) - 1));

    // R4
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_q == '0) && !cnt_hit) |=> (cnt_q == '0));

    // R5
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !cnt_hit) |=> $stable(cnt_q));

    // R6
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_hit |=> (cnt_q == $past(bus_wdata)));

    // R2
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && unmapped) |=> (bus_rdata == '0));

    // R9
    drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_hit && (bus_wdata != '0)) |=> !wd_rst_req);

endmodule

bind wdog_countdown wdog_checker #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .ARM_W  (ARM_W),
    .ARM_BIT(ARM_BIT),
    .A_COUNT(A_COUNT),
    .A_CTRL (A_CTRL),
    .A_ARM  (A_ARM)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .wd_rst_req(wd_rst_req),
    .cnt_q     (cnt_q),
    .en_q      (en_q),
    .arm_q     (arm_q)
);

// File: tb/wdog_countdown_tb.sv
module wdog_countdown_tb;

    localparam logic [1:0]  OP_WR = 2'd0;
    localparam logic [1:0]  OP_RD = 2'd1;
    localparam logic [1:0]  OP_ID = 2'd2;
    localparam logic [19:0] AC = 20'h20324;
    localparam logic [19:0] AT = 20'h20300;
    localparam logic [19:0] AM = 20'h20108;
    localparam logic [19:0] AX = 20'h20000;
    localparam int NVEC = 40;

    // {op, addr, data, expected read, expected reset request}
    localparam logic [86:0] VEC [NVEC] = '{
        {OP_RD, AC, 32'h0, 32'h7FFFFFFF, 1'b0},
        {OP_RD, AT, 32'h0, 32'h00000007, 1'b0},
        {OP_RD, AM, 32'h0, 32'h00000000, 1'b0},
        {OP_RD, AX, 32'h0, 32'h00000000, 1'b0},
        {OP_WR, AC, 32'h5, 32'h0, 1'b0},
        {OP_WR, AT, 32'h17, 32'h0, 1'b0},
        {OP_RD, AC, 32'h0, 32'h5, 1'b0},
        {OP_ID, AC, 32'h0, 32'h0, 1'b0},
        {OP_RD, AC, 32'h0, 32'h3, 1'b0},
        {OP_ID, AC, 32'h0, 32'h0, 1'b0},
        {OP_ID, AC, 32'h0, 32'h0, 1'b0},
        {OP_ID, AC, 32'h0, 32'h0, 1'b0},
        {OP_RD, AC, 32'h0, 32'h0, 1'b0},
        {OP_WR, AM, 32'h2, 32'h0, 1'b1},
        {OP_RD, AM, 32'h0, 32'h2, 1'b1},
        {OP_WR, AC, 32'h3, 32'h0, 1'b0},
        {OP_ID, AC, 32'h0, 32'h0, 1'b0},
        {OP_ID, AC, 32'h0, 32'h0, 1'b0},
        {OP_ID, AC, 32'h0, 32'h0, 1'b1},
        {OP_WR, AM, 32'h0, 32'h0, 1'b0},
        {OP_WR, AM, 32'h2, 32'h0, 1'b1},
        {OP_WR, AT, 32'h07, 32'h0, 1'b1},
        {OP_WR, AC, 32'h9, 32'h0, 1'b0},
        {OP_ID, AC, 32'h0, 32'h0, 1'b0},
        {OP_RD, AC, 32'h0, 32'h9, 1'b0},
        {OP_WR, AT, 32'h17, 32'h0, 1'b0},
        {OP_ID, AC, 32'h0, 32'h0, 1'b0},
        {OP_WR, AT, 32'h07, 32'h0, 1'b0},
        {OP_RD, AC, 32'h0, 32'h7, 1'b0},
        {OP_WR, AT, 32'h17, 32'h0, 1'b0},
        {OP_WR, AC, 32'hFFFFFFFF, 32'h0, 1'b0},
        {OP_RD, AC, 32'h0, 32'hFFFFFFFF, 1'b0},
        {OP_RD, AC, 32'h0, 32'hFFFFFFFE, 1'b0},
        {OP_WR, AC, 32'h1, 32'h0, 1'b0},
        {OP_ID, AC, 32'h0, 32'h0, 1'b1},
        {OP_RD, AC, 32'h0, 32'h0, 1'b1},
        {OP_WR, AX, 32'h5, 32'h0, 1'b1},
        {OP_RD, AC, 32'h0, 32'h0, 1'b1},
        {OP_WR, AM, 32'hFD, 32'h0, 1'b0},
        {OP_RD, AM, 32'h0, 32'hFD, 1'b0}
    };

    // requirement tag checked by each vector
    localparam string TAG [NVEC] = '{
        "R1", "R1", "R1", "R2", "R6", "R3", "R3", "R3", "R3", "R3",
        "R8", "R4", "R4", "R7", "R2", "R9", "R3", "R3", "R7", "R9",
        "R7", "R5", "R9", "R5", "R5", "R3", "R3", "R5", "R5", "R3",
        "R6", "R6", "R10", "R6", "R7", "R4", "R10", "R10", "R8", "R8"
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        wd_rst_req;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    wdog_countdown u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .wd_rst_req(wd_rst_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // one bus operation over exactly one rising edge, from negedge to negedge
    task automatic step(input logic [1:0] op, input logic [19:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = (op == OP_WR);
        bus_rd    = (op == OP_RD);
        @(negedge clk);
        bus_we    = 1'b0;
        bus_rd    = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, NVEC);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", {31'b0, wd_rst_req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][86:85], VEC[i][84:65], VEC[i][64:33]);
            check(TAG[i], {31'b0, wd_rst_req}, {31'b0, VEC[i][0]});
            if (VEC[i][86:85] == OP_RD) begin
                check(TAG[i], bus_rdata, VEC[i][32:1]);
            end
        end

        // R2: no read strobe leaves the read data at zero
        step(OP_ID, AC, 32'h0);
        check("R2", bus_rdata, 32'h0);

        // R1: reset in the middle of a biting, counting state
        step(OP_WR, AM, 32'h2);
        step(OP_WR, AT, 32'h17);
        step(OP_WR, AC, 32'h0);
        check("R7", {31'b0, wd_rst_req}, 32'h1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", {31'b0, wd_rst_req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        step(OP_ID, AC, 32'h0);
        step(OP_ID, AC, 32'h0);
        step(OP_RD, AC, 32'h0);
        check("R1", bus_rdata, 32'h7FFFFFFF);
        step(OP_RD, AT, 32'h0);
        check("R1", bus_rdata, 32'h00000007);
        step(OP_RD, AM, 32'h0);
        check("R1", bus_rdata, 32'h00000000);
        check("R1", {31'b0, wd_rst_req}, 32'h0);

        // R8: zero count with other arm bits set, bit 1 clear
        step(OP_WR, AM, 32'hFD);
        step(OP_WR, AC, 32'h0);
        step(OP_ID, AC, 32'h0);
        check("R8", {31'b0, wd_rst_req}, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule